// File: doc/BRIEF.md
# Line-Buffered Stream Register Bank

This block time-shares one single-ported, line-wide storage array among several narrow stream ports. Each port owns a small stream buffer that holds two full lines. An arbiter lets at most one buffer touch the array in a given cycle, and that access moves a whole line: a read fills one buffer slot, and a write empties one slot into the array. On the client side each buffer trades that line one word at a time over a valid/ready handshake. As a result, many narrow streams appear to run at once against an array that has only one port.

Software gives each buffer a direction, a starting line and a length in words, then pulses its start input. A read stream fetches lines in increasing address order and presents the words in order. A write stream collects words into lines and stores them. A final partial line updates only the words the stream supplied. When the last word has been moved, the buffer drops its busy flag and raises a sticky done flag. The done flag clears on the next accepted start.

Top module: `line_stream_bank`

## Requirements
- R1: After reset every buffer is idle: busy, done, sValidOut, sReadyOut and lineGrant are all zero.
- R2: At most one buffer is granted the array in any cycle (lineGrant is zero or one-hot), and only a busy buffer is granted.
- R3: Buffers that request at the same time are granted in round-robin order. After buffer i is granted, the next grant goes to the first requester found at i+1, i+2, and so on, modulo NUM_BUF.
- R4: A read stream (cfgDir=0) delivers cfgLen words on sDataOut. Word k comes from array line cfgLine + k/LINE_WORDS at word position k mod LINE_WORDS, in increasing k.
- R5: A write stream (cfgDir=1) accepts cfgLen words on sDataIn and stores word k at line cfgLine + k/LINE_WORDS, word position k mod LINE_WORDS. A later read of those words returns them unchanged.
- R6: When a write stream ends partway through a line, only the words it supplied are written in that final line. The other words of that line keep their earlier contents.
- R7: A read buffer fetches at most two lines ahead of its client. With the client stalled, a buffer whose stream spans three or more lines is granted exactly twice.
- R8: A buffer raises done and drops busy once its last word has moved: for a read, when the client takes the last word; for a write, after the final line is stored. Busy and done are never high together.
- R9: A start pulse (together with its direction, line and length) has no effect on a buffer that is busy. The running stream continues unchanged.
- R10: A start with cfgLen=0 sets done in the next cycle without becoming busy or requesting the array.
- R11: While sValidOut is high and sReadyIn is low, sValidOut stays high and sDataOut stays stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | NUM_BUF | Per-buffer start pulse |
| cfgDir | input | NUM_BUF | Per-buffer direction: 0 array-to-client, 1 client-to-array |
| cfgLine | input | NUM_BUF*ADDR_W | Per-buffer starting line address |
| cfgLen | input | NUM_BUF*LEN_W | Per-buffer stream length in words |
| sValidIn | input | NUM_BUF | Write-stream word valid from client |
| sDataIn | input | NUM_BUF*WORD_W | Write-stream word from client |
| sReadyOut | output | NUM_BUF | Write-stream buffer can accept a word |
| sValidOut | output | NUM_BUF | Read-stream word valid to client |
| sDataOut | output | NUM_BUF*WORD_W | Read-stream word to client |
| sReadyIn | input | NUM_BUF | Read-stream client takes the word |
| busy | output | NUM_BUF | Buffer has a stream in progress |
| done | output | NUM_BUF | Sticky end-of-stream flag |
| lineGrant | output | NUM_BUF | Buffer owning the array this cycle |

## Verification
The assertions assume that a client keeps each buffer's direction straight. A client does not raise sValidIn on a buffer running a read stream, or rely on sReadyIn for one running a write stream. The assertions also assume that lines reached by a stream lie within the array. The stimulus drives only the handshake signals that match the direction it configured, and it chooses start lines and lengths so that every stream ends at or before the last line. The hold property on sDataOut relies on the client leaving sReadyIn low while it stalls. The bench keeps sReadyIn constant between negative edges, so this holds.

// File: rtl/lsbk_pkg.sv
package lsbk_pkg;
  localparam int NUM_BUF     = 4;
  localparam int LINE_WORDS  = 8;
  localparam int WORD_W      = 16;
  localparam int DEPTH_LINES = 32;
  localparam int LEN_W       = 10;

  localparam int BUF_W  = $clog2(NUM_BUF);
  localparam int WIDX_W = $clog2(LINE_WORDS);
  localparam int CNT_W  = WIDX_W + 1;
  localparam int ADDR_W = $clog2(DEPTH_LINES);
  localparam int LINE_W = LINE_WORDS * WORD_W;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic                      arrRead;
    logic                      arrWrite;
    logic [BUF_W-1:0]          arrBuf;
    logic                      arrSlot;
    logic [ADDR_W-1:0]         arrLine;
    logic [LINE_WORDS-1:0]     arrMask;
    logic [NUM_BUF-1:0]        pushWord;
    logic [NUM_BUF-1:0]        pushSlot;
    logic [NUM_BUF*WIDX_W-1:0] pushIdx;
    logic [NUM_BUF-1:0]        popSlot;
    logic [NUM_BUF*WIDX_W-1:0] popIdx;
  } lsbkStrobe_t;
endpackage

// File: rtl/lsbk_rr_arbiter.sv
module lsbk_rr_arbiter #(
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grantIdx
);
  logic [IW-1:0] ptrQ;
  logic          found;

  // first requester at or after the pointer, wrapping
  always_comb begin
    grant    = '0;
    grantIdx = '0;
    found    = 1'b0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = int'(ptrQ) + off;
      if (idx >= N) idx = idx - N;
      if (req[idx] && !found) begin
        grant[idx] = 1'b1;
        grantIdx   = IW'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (found) begin
      if (int'(grantIdx) == N - 1) ptrQ <= '0;
      else                         ptrQ <= grantIdx + 1'b1;
    end
  end
endmodule

// File: rtl/lsbk_ctrl.sv
module lsbk_ctrl
  import lsbk_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_BUF-1:0]        cfgStart,
  input  logic [NUM_BUF-1:0]        cfgDir,
  input  logic [NUM_BUF*ADDR_W-1:0] cfgLine,
  input  logic [NUM_BUF*LEN_W-1:0]  cfgLen,
  input  logic [NUM_BUF-1:0]        sValidIn,
  input  logic [NUM_BUF-1:0]        sReadyIn,
  output logic [NUM_BUF-1:0]        sReadyOut,
  output logic [NUM_BUF-1:0]        sValidOut,
  output logic [NUM_BUF-1:0]        busy,
  output logic [NUM_BUF-1:0]        done,
  output logic [NUM_BUF-1:0]        lineGrant,
  output lsbkStrobe_t               st
);
  // per-buffer state
  logic [NUM_BUF-1:0] busyQ, doneQ, dirQ, headQ, tailQ;
  logic [ADDR_W-1:0]  lineQ      [NUM_BUF];
  logic [LEN_W-1:0]   linesLeftQ [NUM_BUF];
  logic [LEN_W-1:0]   wordsLeftQ [NUM_BUF];
  logic [1:0]         occQ       [NUM_BUF];
  logic [WIDX_W-1:0]  idxQ       [NUM_BUF];
  logic [CNT_W-1:0]   cntQ       [NUM_BUF][2];

  // per-buffer decode
  logic [NUM_BUF-1:0] req, grant, hs, lineEnd, incLine, decLine;
  logic [1:0]         occNext   [NUM_BUF];
  logic [LEN_W-1:0]   wordsNext [NUM_BUF];
  logic [BUF_W-1:0]   gIdx;

  lsbk_rr_arbiter #(.N(NUM_BUF)) uArb (
    .clk(clk), .rstN(rstN), .req(req), .grant(grant), .grantIdx(gIdx)
  );

  always_comb begin
    for (int b = 0; b < NUM_BUF; b++) begin
      lineEnd[b]   = (idxQ[b] == WIDX_W'(LINE_WORDS - 1)) || (wordsLeftQ[b] == LEN_W'(1));
      sReadyOut[b] = busyQ[b] & dirQ[b] & (wordsLeftQ[b] != '0) & (occQ[b] != 2'd2);
      sValidOut[b] = busyQ[b] & ~dirQ[b] & (occQ[b] != 2'd0);
      hs[b]        = dirQ[b] ? (sReadyOut[b] & sValidIn[b]) : (sValidOut[b] & sReadyIn[b]);
      req[b]       = busyQ[b] & (dirQ[b] ? (occQ[b] != 2'd0)
                                         : ((linesLeftQ[b] != '0) && (occQ[b] != 2'd2)));
      incLine[b]   = dirQ[b] ? (hs[b] & lineEnd[b]) : grant[b];
      decLine[b]   = dirQ[b] ? grant[b] : (hs[b] & lineEnd[b]);
      occNext[b]   = occQ[b] + {1'b0, incLine[b]} - {1'b0, decLine[b]};
      wordsNext[b] = wordsLeftQ[b] - LEN_W'(hs[b]);
    end
  end

  // strobe bundle toward the datapath
  always_comb begin
    st          = '0;
    st.arrRead  = (|grant) & ~dirQ[gIdx];
    st.arrWrite = (|grant) & dirQ[gIdx];
    st.arrBuf   = gIdx;
    st.arrSlot  = dirQ[gIdx] ? headQ[gIdx] : tailQ[gIdx];
    st.arrLine  = lineQ[gIdx];
    for (int w = 0; w < LINE_WORDS; w++)
      st.arrMask[w] = CNT_W'(w) < cntQ[gIdx][headQ[gIdx]];
    st.pushWord = sReadyOut & sValidIn;
    st.pushSlot = tailQ;
    st.popSlot  = headQ;
    for (int b = 0; b < NUM_BUF; b++) begin
      st.pushIdx[b*WIDX_W +: WIDX_W] = idxQ[b];
      st.popIdx[b*WIDX_W +: WIDX_W]  = idxQ[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= '0; doneQ <= '0; dirQ <= '0; headQ <= '0; tailQ <= '0;
      for (int b = 0; b < NUM_BUF; b++) begin
        lineQ[b]      <= '0;
        linesLeftQ[b] <= '0;
        wordsLeftQ[b] <= '0;
        occQ[b]       <= '0;
        idxQ[b]       <= '0;
        cntQ[b][0]    <= '0;
        cntQ[b][1]    <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BUF; b++) begin
        if (cfgStart[b] && !busyQ[b]) begin
          dirQ[b]       <= cfgDir[b];
          lineQ[b]      <= cfgLine[b*ADDR_W +: ADDR_W];
          wordsLeftQ[b] <= cfgLen[b*LEN_W +: LEN_W];
          linesLeftQ[b] <= LEN_W'((32'(cfgLen[b*LEN_W +: LEN_W]) + LINE_WORDS - 1) / LINE_WORDS);
          occQ[b]       <= '0;
          idxQ[b]       <= '0;
          headQ[b]      <= 1'b0;
          tailQ[b]      <= 1'b0;
          busyQ[b]      <= (cfgLen[b*LEN_W +: LEN_W] != '0);
          doneQ[b]      <= (cfgLen[b*LEN_W +: LEN_W] == '0);
        end else if (busyQ[b]) begin
          if (grant[b]) begin
            lineQ[b] <= lineQ[b] + 1'b1;
            if (!dirQ[b]) linesLeftQ[b] <= linesLeftQ[b] - 1'b1;
          end
          if (incLine[b]) tailQ[b] <= ~tailQ[b];
          if (decLine[b]) headQ[b] <= ~headQ[b];
          if (hs[b]) begin
            wordsLeftQ[b] <= wordsNext[b];
            idxQ[b]       <= lineEnd[b] ? '0 : idxQ[b] + 1'b1;
            if (dirQ[b] && lineEnd[b])
              cntQ[b][tailQ[b]] <= CNT_W'(idxQ[b]) + 1'b1;
          end
          occQ[b] <= occNext[b];
          if (wordsNext[b] == '0 && occNext[b] == 2'd0) begin
            busyQ[b] <= 1'b0;
            doneQ[b] <= 1'b1;
          end
        end
      end
    end
  end

  assign busy      = busyQ;
  assign done      = doneQ;
  assign lineGrant = grant;
endmodule

// File: rtl/lsbk_datapath.sv
module lsbk_datapath
  import lsbk_pkg::*;
(
  input  logic                      clk,
  input  lsbkStrobe_t               st,
  input  logic [NUM_BUF*WORD_W-1:0] sDataIn,
  output logic [NUM_BUF*WORD_W-1:0] sDataOut
);
  logic [LINE_W-1:0] arrMem  [DEPTH_LINES];
  logic [LINE_W-1:0] lineBuf [NUM_BUF][2];

  always_ff @(posedge clk) begin
    // single array port: one line read or one masked line write
    if (st.arrRead)
      lineBuf[st.arrBuf][st.arrSlot] <= arrMem[st.arrLine];
    if (st.arrWrite) begin
      for (int w = 0; w < LINE_WORDS; w++)
        if (st.arrMask[w])
          arrMem[st.arrLine][w*WORD_W +: WORD_W] <= lineBuf[st.arrBuf][st.arrSlot][w*WORD_W +: WORD_W];
    end
    for (int b = 0; b < NUM_BUF; b++)
      if (st.pushWord[b])
        lineBuf[b][st.pushSlot[b]][st.pushIdx[b*WIDX_W +: WIDX_W]*WORD_W +: WORD_W]
          <= sDataIn[b*WORD_W +: WORD_W];
  end

  always_comb begin
    for (int b = 0; b < NUM_BUF; b++)
      sDataOut[b*WORD_W +: WORD_W] =
        lineBuf[b][st.popSlot[b]][st.popIdx[b*WIDX_W +: WIDX_W]*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/line_stream_bank.sv
module line_stream_bank
  import lsbk_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_BUF-1:0]        cfgStart,
  input  logic [NUM_BUF-1:0]        cfgDir,
  input  logic [NUM_BUF*ADDR_W-1:0] cfgLine,
  input  logic [NUM_BUF*LEN_W-1:0]  cfgLen,
  input  logic [NUM_BUF-1:0]        sValidIn,
  input  logic [NUM_BUF*WORD_W-1:0] sDataIn,
  output logic [NUM_BUF-1:0]        sReadyOut,
  output logic [NUM_BUF-1:0]        sValidOut,
  output logic [NUM_BUF*WORD_W-1:0] sDataOut,
  input  logic [NUM_BUF-1:0]        sReadyIn,
  output logic [NUM_BUF-1:0]        busy,
  output logic [NUM_BUF-1:0]        done,
  output logic [NUM_BUF-1:0]        lineGrant
);
  lsbkStrobe_t st;

  lsbk_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgStart(cfgStart), .cfgDir(cfgDir), .cfgLine(cfgLine), .cfgLen(cfgLen),
    .sValidIn(sValidIn), .sReadyIn(sReadyIn),
    .sReadyOut(sReadyOut), .sValidOut(sValidOut),
    .busy(busy), .done(done), .lineGrant(lineGrant), .st(st)
  );

  lsbk_datapath uData (
    .clk(clk), .st(st), .sDataIn(sDataIn), .sDataOut(sDataOut)
  );
endmodule

// File: rtl/lsbk_checker.sv
module lsbk_checker
  import lsbk_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_BUF-1:0]        lineGrant,
  input logic [NUM_BUF-1:0]        busy,
  input logic [NUM_BUF-1:0]        done,
  input logic [NUM_BUF-1:0]        sValidOut,
  input logic [NUM_BUF-1:0]        sReadyIn,
  input logic [NUM_BUF-1:0]        sReadyOut,
  input logic [NUM_BUF*WORD_W-1:0] sDataOut
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lineGrant));

  for (genvar b = 0; b < NUM_BUF; b++) begin : gChk
    assert_grant_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
      lineGrant[b] |-> busy[b]);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
      !(busy[b] && done[b]));
    assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(done[b]) |-> !busy[b]);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
      (sValidOut[b] && !sReadyIn[b]) |=>
        (sValidOut[b] && $stable(sDataOut[b*WORD_W +: WORD_W])));
    assert_ready_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
      sReadyOut[b] |-> (busy[b] && !sValidOut[b]));
  end
endmodule

bind line_stream_bank lsbk_checker uChk (
  .clk(clk), .rstN(rstN), .lineGrant(lineGrant), .busy(busy), .done(done),
  .sValidOut(sValidOut), .sReadyIn(sReadyIn), .sReadyOut(sReadyOut),
  .sDataOut(sDataOut)
);

// File: tb/tb_line_stream_bank.sv
module tb_line_stream_bank;
  import lsbk_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_BUF-1:0]        cfgStart = '0, cfgDir = '0, sValidIn = '0, sReadyIn = '0;
  logic [NUM_BUF*ADDR_W-1:0] cfgLine = '0;
  logic [NUM_BUF*LEN_W-1:0]  cfgLen = '0;
  logic [NUM_BUF*WORD_W-1:0] sDataIn = '0;
  logic [NUM_BUF-1:0]        sReadyOut, sValidOut, busy, done, lineGrant;
  logic [NUM_BUF*WORD_W-1:0] sDataOut;

  always #5 clk = ~clk;

  line_stream_bank dut (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [WORD_W-1:0] model [DEPTH_LINES*LINE_WORDS];

  // {write buffer, read buffer, start line, length, seed}
  localparam int VEC [6][5] = '{
    '{0, 1,  0,  8, 100},
    '{1, 2,  2,  1, 200},
    '{2, 3,  4, 13, 300},
    '{3, 0,  8, 24, 400},
    '{0, 2, 12,  7, 500},
    '{1, 3, 31,  8, 600}
  };

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic pulseStart(int b, bit dir, int line, int len);
    @(negedge clk);
    cfgDir[b] = dir;
    cfgLine[b*ADDR_W +: ADDR_W] = ADDR_W'(line);
    cfgLen[b*LEN_W +: LEN_W] = LEN_W'(len);
    cfgStart[b] = 1'b1;
    @(negedge clk);
    cfgStart[b] = 1'b0;
  endtask

  task automatic waitDone(int b, string tag);
    int t = 0;
    while (!done[b] && t < 300) begin @(negedge clk); t++; end
    check(done[b] && !busy[b], tag, int'({done[b], busy[b]}), 2);
  endtask

  task automatic writeStream(int b, int line, int len, int seed);
    int k = 0;
    int guard = 0;
    pulseStart(b, 1'b1, line, len);
    while (k < len && guard < 500) begin
      sValidIn[b] = 1'b1;
      sDataIn[b*WORD_W +: WORD_W] = WORD_W'(seed + k);
      if (sReadyOut[b]) begin
        model[line*LINE_WORDS + k] = WORD_W'(seed + k);
        k++;
      end
      @(negedge clk);
      guard++;
    end
    sValidIn[b] = 1'b0;
    waitDone(b, "R8 write done");
  endtask

  task automatic consume(int b, int line, int len, string tag);
    int k = 0;
    int guard = 0;
    sReadyIn[b] = 1'b1;
    while (k < len && guard < 500) begin
      if (sValidOut[b]) begin
        check(sDataOut[b*WORD_W +: WORD_W] == model[line*LINE_WORDS + k], tag,
              int'(sDataOut[b*WORD_W +: WORD_W]), int'(model[line*LINE_WORDS + k]));
        k++;
      end
      @(negedge clk);
      guard++;
    end
    check(k == len, {tag, " word count"}, k, len);
    sReadyIn[b] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == '0 && done == '0, "R1 busy/done", int'({busy, done}), 0);
    check(sValidOut == '0 && sReadyOut == '0, "R1 handshakes", int'({sValidOut, sReadyOut}), 0);
    check(lineGrant == '0, "R1 grant", int'(lineGrant), 0);

    // R4 R5: write then read back through another buffer
    for (int v = 0; v < 6; v++) begin
      writeStream(VEC[v][0], VEC[v][2], VEC[v][3], VEC[v][4]);
      pulseStart(VEC[v][1], 1'b0, VEC[v][2], VEC[v][3]);
      consume(VEC[v][1], VEC[v][2], VEC[v][3], "R4 R5 read back");
      waitDone(VEC[v][1], "R8 read done");
    end

    // R6: partial last line leaves the other words untouched
    writeStream(0, 20, 8, 700);
    writeStream(1, 20, 3, 900);
    check(model[20*LINE_WORDS + 3] == WORD_W'(703), "R6 model", int'(model[163]), 703);
    pulseStart(2, 1'b0, 20, 8);
    consume(2, 20, 8, "R6 masked line");
    waitDone(2, "R6 done");

    // R10: zero length
    pulseStart(0, 1'b0, 5, 0);
    check(done[0] && !busy[0], "R10 immediate done", int'({done[0], busy[0]}), 2);
    check(lineGrant == '0, "R10 no grant", int'(lineGrant), 0);

    // R9 R11: restart while busy is ignored; stalled data holds
    begin
      logic [WORD_W-1:0] d1, d2;
      pulseStart(1, 1'b0, 0, 8);
      repeat (3) @(negedge clk);
      d1 = sDataOut[1*WORD_W +: WORD_W];
      pulseStart(1, 1'b1, 20, 3);
      check(sReadyOut[1] == 1'b0 && busy[1], "R9 config ignored", int'(sReadyOut[1]), 0);
      d2 = sDataOut[1*WORD_W +: WORD_W];
      check(d1 == d2, "R11 stalled data stable", int'(d2), int'(d1));
      check(d1 == model[0], "R9 first word", int'(d1), int'(model[0]));
      consume(1, 0, 8, "R9 stream unchanged");
      waitDone(1, "R9 done");
    end

    // R3 R7: four stalled read streams of three lines each
    begin
      int seq [16];
      int n = 0;
      int perBuf [NUM_BUF];
      bit orderOk = 1;
      for (int b = 0; b < NUM_BUF; b++) perBuf[b] = 0;
      @(negedge clk);
      for (int b = 0; b < NUM_BUF; b++) begin
        cfgDir[b] = 1'b0;
        cfgLine[b*ADDR_W +: ADDR_W] = ADDR_W'(b * 4);
        cfgLen[b*LEN_W +: LEN_W] = LEN_W'(24);
      end
      cfgStart = '1;
      @(negedge clk);
      cfgStart = '0;
      for (int c = 0; c < 14; c++) begin
        for (int b = 0; b < NUM_BUF; b++)
          if (lineGrant[b]) begin
            if (n < 16) seq[n] = b;
            n++;
            perBuf[b]++;
          end
        @(negedge clk);
      end
      check(n == 8, "R7 total grants", n, 8);
      for (int b = 0; b < NUM_BUF; b++)
        check(perBuf[b] == 2, "R7 lines ahead per buffer", perBuf[b], 2);
      for (int i = 1; i < 8 && i < n; i++)
        if (seq[i] != (seq[i-1] + 1) % NUM_BUF) orderOk = 0;
      check(orderOk, "R3 round-robin order", int'(orderOk), 1);
      sReadyIn = '1;
      for (int b = 0; b < NUM_BUF; b++) waitDone(b, "R8 drain done");
      sReadyIn = '0;
    end

    summary();
  end
endmodule